// File: doc/BRIEF.md
# Serial Divisible-by-Three Detector

This block watches a serial bit stream, one bit per clock cycle, and reports after every accepted bit whether the number formed by all bits since the last reset or clear is a multiple of three. The first bit accepted is the most significant one. Each new bit doubles the running value and adds itself. The block keeps only the remainder of that value modulo three, held in three states.

A bit is taken only in a cycle where the input strobe is high. In the following cycle a registered flag marks the verdict output as fresh. Cycles with the strobe low leave the remainder untouched. A synchronous active-low reset, or a one-cycle clear pulse, starts a new number from remainder zero.

The verdict is computed as a Mealy output: it is taken from the transition, and it is 1 exactly when the transition lands in the zero-remainder state.

Top module: `div3_stream_detector`

## Requirements
- R1: While `rst_n` is low at a rising edge, the machine returns to remainder zero, and both `mult3_o` and `mult3_vld_o` read 0 after that edge.
- R2: After each accepted bit, `mult3_o` is 1 if and only if the binary value of all bits accepted since the last reset or clear is divisible by three, with the earliest bit most significant.
- R3: A bit is accepted at a rising edge where `bit_vld_i` is 1 and `clr_i` is 0. Its verdict appears on the outputs just after that same edge, with `mult3_vld_o` = 1. When the bit strobe is high on back-to-back edges, a fresh verdict follows every edge.
- R4: At an edge where `bit_vld_i` is 0 and `clr_i` is 0, the remainder is unchanged whatever `bit_i` is, `mult3_vld_o` goes to 0, and `mult3_o` keeps its previous value.
- R5: At an edge where `clr_i` is 1, the remainder returns to zero and any bit offered in that cycle is dropped. After that edge, `mult3_vld_o` = 0 and `mult3_o` = 0.
- R6: From remainder zero, the bit sequence 1,1,1,0,0,1,0 yields the verdicts 0,1,0,0,0,1,1 in that order.
- R7: Zero bits accepted at remainder zero keep the remainder at zero, and each one yields verdict 1.
- R8: At remainder two, a 1 bit keeps the remainder at two with verdict 0, and a 0 bit moves it to remainder one with verdict 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| clr_i | input | 1 | Synchronous clear to remainder zero; takes priority over a bit |
| bit_vld_i | input | 1 | Strobe: `bit_i` is taken at this edge |
| bit_i | input | 1 | Next serial bit, most significant first |
| mult3_o | output | 1 | Verdict: the value seen so far is a multiple of three |
| mult3_vld_o | output | 1 | `mult3_o` was updated by a bit accepted at the last edge |

## Verification
A wrong remainder state shows up at the ports as a wrong verdict, but not always at once. A state that drifts from one nonzero remainder to the other keeps giving 0 until the stream next reaches a multiple of three, so long random streams are compared with a software modulo model rather than short patterns alone. A state that moves during idle or cleared cycles shows up at the first bit accepted after them. Each such case is therefore probed by feeding a bit right after the idle or cleared cycles.

// File: rtl/div3_pkg.sv
// Package: shared remainder state encoding for the divisible-by-three detector.
// Assumes a 2-bit state; code 2'b11 is never produced and is decoded as zero.
package div3_pkg;

    localparam int REM_W = 2;

    typedef enum logic [REM_W-1:0] {
        REM_ZERO = 2'b00,
        REM_ONE  = 2'b01,
        REM_TWO  = 2'b10
    } rem_t;

endpackage

// File: rtl/div3_step.sv
// Module: div3_step
// Purely combinational transition rule: new remainder = (2*old + bit) mod 3.
// The hit flag is the Mealy output and is set when the new remainder is zero.
// Assumes the illegal code 2'b11 should behave like remainder zero.
module div3_step
    import div3_pkg::*;
(
    input  rem_t cur_i,
    input  logic bit_i,
    output rem_t nxt_o,
    output logic hit_o
);

    // Transition table with the unused code folded onto remainder zero
    always_comb begin
        case (cur_i)
            REM_ONE: nxt_o = bit_i ? REM_ZERO : REM_TWO;
            REM_TWO: nxt_o = bit_i ? REM_TWO  : REM_ONE;
            default: nxt_o = bit_i ? REM_ONE  : REM_ZERO;
        endcase
    end

    // Output rule: the transition lands in the zero-remainder state
    always_comb begin
        hit_o = (nxt_o == REM_ZERO);
    end

endmodule

// File: rtl/div3_state_reg.sv
// Module: div3_state_reg
// Holds the remainder state. Reset and clear both load zero; otherwise the
// state advances only when an accepted bit is present.
// Assumes rst_n is synchronous and active low, and clear outranks advance.
module div3_state_reg
    import div3_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic adv_i,
    input  rem_t nxt_i,
    output rem_t cur_o
);

    // State register with synchronous reset, clear, and advance enable
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cur_o <= REM_ZERO;
        end else if (adv_i) begin
            cur_o <= nxt_i;
        end
    end

    // R2
    state_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_o != 2'b11);

    // R4
    state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_i && !clr_i) |=> $stable(cur_o));

    // R5
    state_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cur_o == REM_ZERO));

endmodule

// File: rtl/div3_out_reg.sv
// Module: div3_out_reg
// Registers the Mealy verdict and its valid flag. The verdict holds across
// idle cycles; a clear or reset zeroes both outputs.
// Assumes adv_i is already qualified by the absence of a clear.
module div3_out_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic adv_i,
    input  logic hit_i,
    output logic mult3_o,
    output logic mult3_vld_o
);

    // Verdict register: loads on an accepted bit, holds otherwise
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            mult3_o <= 1'b0;
        end else if (adv_i) begin
            mult3_o <= hit_i;
        end
    end

    // Valid flag: high for exactly the cycle after an accepted bit
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            mult3_vld_o <= 1'b0;
        end else begin
            mult3_vld_o <= adv_i;
        end
    end

    // R3
    out_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i |=> mult3_vld_o);

    // R4
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_i && !clr_i) |=> ($stable(mult3_o) && !mult3_vld_o));

    // R5
    out_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (!mult3_o && !mult3_vld_o));

endmodule

// File: rtl/div3_stream_detector.sv
// Module: div3_stream_detector
// Top of the serial divisible-by-three detector. Qualifies the bit strobe
// with clear, steps the remainder machine and registers the Mealy verdict.
// Assumes one bit per cycle at most, most significant bit first.
module div3_stream_detector
    import div3_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic bit_vld_i,
    input  logic bit_i,
    output logic mult3_o,
    output logic mult3_vld_o
);

    rem_t cur_rem;
    rem_t nxt_rem;
    logic step_hit;
    logic accept;

    // Accept a bit only when no clear is requested in the same cycle
    always_comb begin
        accept = bit_vld_i && !clr_i;
    end

    div3_step u_step (
        .cur_i (cur_rem),
        .bit_i (bit_i),
        .nxt_o (nxt_rem),
        .hit_o (step_hit)
    );

    div3_state_reg u_state (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clr_i),
        .adv_i (accept),
        .nxt_i (nxt_rem),
        .cur_o (cur_rem)
    );

    div3_out_reg u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (clr_i),
        .adv_i       (accept),
        .hit_i       (step_hit),
        .mult3_o     (mult3_o),
        .mult3_vld_o (mult3_vld_o)
    );

    // R2
    verdict_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mult3_vld_o |-> (mult3_o == (cur_rem == REM_ZERO)));

endmodule

// File: tb/div3_stream_detector_bench.sv
module div3_stream_detector_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr_i = 1'b0;
    logic bit_vld_i = 1'b0;
    logic bit_i = 1'b0;
    logic mult3_o;
    logic mult3_vld_o;

    int n_run = 0;
    int n_fail = 0;
    int model_rem = 0;
    logic last_out = 1'b0;

    always #10 clk = ~clk;

    div3_stream_detector u_div3_stream_detector (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (clr_i),
        .bit_vld_i   (bit_vld_i),
        .bit_i       (bit_i),
        .mult3_o     (mult3_o),
        .mult3_vld_o (mult3_vld_o)
    );

    function automatic int next_rem(int r, logic b);
        return (2 * r + int'(b)) % 3;
    endfunction

    task automatic check(string tag, logic got, logic exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", tag, got, exp);
        end
    endtask

    // Called at a falling edge; leaves the bench at the next falling edge
    task automatic feed(logic b, string tag);
        bit_vld_i = 1'b1;
        bit_i = b;
        clr_i = 1'b0;
        @(negedge clk);
        bit_vld_i = 1'b0;
        model_rem = next_rem(model_rem, b);
        last_out = (model_rem == 0);
        check({tag, " valid"}, mult3_vld_o, 1'b1);
        check(tag, mult3_o, last_out);
    endtask

    task automatic idle(logic junk);
        bit_vld_i = 1'b0;
        bit_i = junk;
        clr_i = 1'b0;
        @(negedge clk);
        check("R4 valid low", mult3_vld_o, 1'b0);
        check("R4 hold", mult3_o, last_out);
    endtask

    task automatic clear(logic with_bit);
        clr_i = 1'b1;
        bit_vld_i = with_bit;
        bit_i = 1'b1;
        @(negedge clk);
        clr_i = 1'b0;
        bit_vld_i = 1'b0;
        model_rem = 0;
        last_out = 1'b0;
        check("R5 valid", mult3_vld_o, 1'b0);
        check("R5 verdict", mult3_o, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [6:0] ref_bits;
        logic [6:0] ref_outs;
        void'($urandom(32'd411));
        ref_bits = 7'b1110010;
        ref_outs = 7'b0100011;

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 verdict", mult3_o, 1'b0);
        check("R1 valid", mult3_vld_o, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6: reference sequence, fed back to back
        for (int i = 6; i >= 0; i--) begin
            feed(ref_bits[i], "R6 model");
            check("R6 table", mult3_o, ref_outs[i]);
        end

        // R1: reset in mid-stream while a bit is offered
        feed(1'b1, "R2");
        rst_n = 1'b0;
        bit_vld_i = 1'b1;
        bit_i = 1'b0;
        @(negedge clk);
        bit_vld_i = 1'b0;
        check("R1 mid verdict", mult3_o, 1'b0);
        check("R1 mid valid", mult3_vld_o, 1'b0);
        rst_n = 1'b1;
        model_rem = 0;
        last_out = 1'b0;
        feed(1'b1, "R1 state zero");

        // R7: leading zeros from remainder zero
        clear(1'b0);
        feed(1'b0, "R7");
        feed(1'b0, "R7");
        feed(1'b0, "R7");

        // R8: remainder two behaviour
        clear(1'b0);
        feed(1'b1, "R8 setup");
        feed(1'b0, "R8 setup");
        feed(1'b1, "R8 stay");
        feed(1'b1, "R8 stay");
        feed(1'b0, "R8 move");
        feed(1'b1, "R8 back");

        // R4: idle cycles with toggling data change nothing
        clear(1'b0);
        feed(1'b1, "R4 setup");
        idle(1'b1);
        idle(1'b0);
        idle(1'b1);
        feed(1'b1, "R4 after idle");

        // R5: clear drops a bit offered in the same cycle
        feed(1'b1, "R5 setup");
        clear(1'b1);
        feed(1'b1, "R5 after clear");
        feed(1'b1, "R5 after clear");

        // R3/R2: random stream with gaps and rare clears
        clear(1'b0);
        for (int n = 0; n < 3000; n++) begin
            int pick;
            pick = $urandom_range(0, 99);
            if (pick < 2) begin
                clear(1'($urandom_range(0, 1)));
            end else if (pick < 20) begin
                idle(1'($urandom_range(0, 1)));
            end else begin
                feed(1'($urandom_range(0, 1)), "R3 R2 random");
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule